// File: doc/BRIEF.md
# Relative-Indexed Operand History Buffer

This block keeps the results of the most recently retired instructions, together with their condition flags, so that a consumer can name an operand by how far back it was produced instead of by a register number. Each accepted write records one retired result and its flags. Two data read ports and one flag read port each take a distance `k` and return, one cycle later, what the instruction `k` positions back produced. A flag test can therefore look at an older flag entry while a newer flag-setting result has not yet been written.

The current window sits on a small stack of windows. A push keeps the current window intact and opens a fresh empty one, for example on entry to an inner loop or a recursive call. A pop discards the current window and brings back the window that was saved, with its contents and fill level unchanged. The history depth and the stack depth are parameters. The depth must be a power of two.

Results enter through a valid/ready port. `wr_ready` drops only in a cycle where `push` or `pop` is asserted. A result offered in such a cycle is not taken, and the producer must hold it and offer it again. In every other cycle a valid result is taken at once. Reads, push, pop and the two error pulses are plain level signals.

Top module: `opnd_hist_buf`

## Requirements
- R1: Distance 1 returns the newest stored result, and distance `k` returns the result written `k` accepted writes earlier. The value appears on the read outputs one clock after the distance is presented.
- R2: A distance of 0, or a distance larger than the number of entries in the current window, gives error = 1 and value 0 on that port. A valid read gives error = 0.
- R3: A window holds at most DEPTH entries. Once it is full, each new write drops the oldest entry, and distance DEPTH returns the oldest entry still held.
- R4: The flag port uses the same distance rules as the data ports and returns the FW-bit flags stored with that result.
- R5: A read presented in the same cycle as an accepted write sees the window as it was before that write.
- R6: An accepted push opens an empty window. Every read then gives error until new writes arrive, and those writes land only in the new window.
- R7: A pop returns to the previously saved window with its entries and fill level unchanged.
- R8: A push while NSAVE windows are already saved is ignored. `ovf` is then high for exactly the following cycle.
- R9: A pop with no saved window (push low) is ignored. `udf` is then high for exactly the following cycle.
- R10: `wr_ready` is 0 in any cycle where `push` or `pop` is 1, and a result offered in that cycle is not stored. `wr_ready` is 1 otherwise.
- R11: After reset, every window is empty, the stack level is zero, and all read outputs, errors, `ovf` and `udf` are 0.
- R12: When `push` and `pop` are high together, the push is handled and the pop is ignored. No `udf` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | A retired result is offered |
| wr_ready | output | 1 | The result is taken in this cycle |
| wr_data | input | DW | Result value |
| wr_flags | input | FW | Result flags (N, Z, C, V by convention) |
| rd_a_idx | input | IW | Distance back for data port A |
| rd_a_data | output | DW | Registered value for port A |
| rd_a_err | output | 1 | Port A distance is out of range |
| rd_b_idx | input | IW | Distance back for data port B |
| rd_b_data | output | DW | Registered value for port B |
| rd_b_err | output | 1 | Port B distance is out of range |
| rd_f_idx | input | IW | Distance back for the flag port |
| rd_f_flags | output | FW | Registered flags for the flag port |
| rd_f_err | output | 1 | Flag port distance is out of range |
| push | input | 1 | Save the current window and open an empty one |
| pop | input | 1 | Drop the current window and restore the saved one |
| ovf | output | 1 | Pulse: a push was refused because the stack is full |
| udf | output | 1 | Pulse: a pop was refused because the stack is empty |

## Verification
The properties assume that every input is synchronous and stable around the rising edge. They also assume that a producer whose offer is refused during a push or pop cycle presents it again later. The property on the newest result relies on nothing but the write handshake and the one-cycle read latency, so it has to hold across any mix of stack operations. The bench changes inputs only on falling clock edges. It uses a depth-4, two-save configuration, so every distance the index field can encode, every fill level and every stack level is reached. It also exercises the refused writes, the refused pushes and pops, and the combined push/pop.

// File: rtl/ohb_pkg.sv
package ohb_pkg;
  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/ohb_stack_ctl.sv
module ohb_stack_ctl
  import ohb_pkg::*;
#(
  parameter int NSAVE = 4,
  parameter int SPW   = $clog2(NSAVE + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic           pop,
  output logic [SPW-1:0] sp,
  output stk_op_e        op,
  output logic           ovf,
  output logic           udf
);
  localparam logic [SPW-1:0] TOP = SPW'(NSAVE);

  // push outranks pop; refused requests become HOLD
  always_comb begin
    op = STK_HOLD;
    if (push) begin
      if (sp != TOP) op = STK_PUSH;
    end else if (pop) begin
      if (sp != '0) op = STK_POP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp  <= '0;
      ovf <= 1'b0;
      udf <= 1'b0;
    end else begin
      ovf <= push && (sp == TOP);
      udf <= !push && pop && (sp == '0);
      case (op)
        STK_PUSH: sp <= sp + 1'b1;
        STK_POP:  sp <= sp - 1'b1;
        default:  sp <= sp;
      endcase
    end
  end
endmodule

// File: rtl/ohb_bank.sv
module ohb_bank #(
  parameter int DW    = 32,
  parameter int FW    = 4,
  parameter int DEPTH = 16,
  parameter int IW    = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                we,
  input  logic [DW-1:0]       wdata,
  input  logic [FW-1:0]       wflags,
  input  logic [1:0][IW-1:0]  idx_d,
  output logic [1:0][DW-1:0]  dat_d,
  output logic [1:0]          ok_d,
  input  logic [IW-1:0]       idx_f,
  output logic [FW-1:0]       flg_f,
  output logic                ok_f
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [IW-1:0] FULL = IW'(DEPTH);

  logic [DW+FW-1:0] mem [DEPTH];
  logic [AW-1:0]    head;   // next slot to fill
  logic [IW-1:0]    cnt;    // entries held

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      head <= '0;
      cnt  <= '0;
    end else if (we) begin
      head <= head + 1'b1;
      if (cnt != FULL) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we && rst_n && !clr) mem[head] <= {wflags, wdata};
  end

  function automatic logic [AW-1:0] slot(input logic [AW-1:0] h, input logic [IW-1:0] k);
    return h - k[AW-1:0];
  endfunction

  function automatic logic inside_win(input logic [IW-1:0] k, input logic [IW-1:0] c);
    return (k != '0) && (k <= c);
  endfunction

  for (genvar p = 0; p < 2; p++) begin : g_dport
    assign ok_d[p]  = inside_win(idx_d[p], cnt);
    assign dat_d[p] = mem[slot(head, idx_d[p])][DW-1:0];
  end

  assign ok_f  = inside_win(idx_f, cnt);
  assign flg_f = mem[slot(head, idx_f)][DW+FW-1:DW];
endmodule

// File: rtl/opnd_hist_buf.sv
module opnd_hist_buf
  import ohb_pkg::*;
#(
  parameter int DW    = 32,
  parameter int FW    = 4,
  parameter int DEPTH = 16,
  parameter int NSAVE = 4,
  localparam int IW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic [FW-1:0] wr_flags,
  input  logic [IW-1:0] rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  output logic          rd_a_err,
  input  logic [IW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  output logic          rd_b_err,
  input  logic [IW-1:0] rd_f_idx,
  output logic [FW-1:0] rd_f_flags,
  output logic          rd_f_err,
  input  logic          push,
  input  logic          pop,
  output logic          ovf,
  output logic          udf
);
  localparam int NB  = NSAVE + 1;
  localparam int SPW = $clog2(NB);

  logic [SPW-1:0] sp;
  stk_op_e        op;
  logic           wr_fire;

  ohb_stack_ctl #(.NSAVE(NSAVE), .SPW(SPW)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .sp(sp), .op(op), .ovf(ovf), .udf(udf)
  );

  assign wr_ready = !(push || pop);
  assign wr_fire  = wr_valid && wr_ready;

  logic [1:0][DW-1:0] b_dat [NB];
  logic [1:0]         b_okd [NB];
  logic [FW-1:0]      b_flg [NB];
  logic               b_okf [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic clr_b, we_b;
    if (b == 0) begin : g_base
      assign clr_b = 1'b0;
    end else begin : g_upper
      assign clr_b = (op == STK_PUSH) && (sp == SPW'(b - 1));
    end
    assign we_b = wr_fire && (sp == SPW'(b));

    ohb_bank #(.DW(DW), .FW(FW), .DEPTH(DEPTH), .IW(IW)) u_bank (
      .clk(clk), .rst_n(rst_n), .clr(clr_b), .we(we_b),
      .wdata(wr_data), .wflags(wr_flags),
      .idx_d({rd_b_idx, rd_a_idx}), .dat_d(b_dat[b]), .ok_d(b_okd[b]),
      .idx_f(rd_f_idx), .flg_f(b_flg[b]), .ok_f(b_okf[b])
    );
  end

  logic [1:0][DW-1:0] cur_dat;
  logic [1:0]         cur_okd;
  logic [FW-1:0]      cur_flg;
  logic               cur_okf;

  always_comb begin
    cur_dat = b_dat[sp];
    cur_okd = b_okd[sp];
    cur_flg = b_flg[sp];
    cur_okf = b_okf[sp];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_a_data  <= '0;
      rd_a_err   <= 1'b0;
      rd_b_data  <= '0;
      rd_b_err   <= 1'b0;
      rd_f_flags <= '0;
      rd_f_err   <= 1'b0;
    end else begin
      rd_a_data  <= cur_okd[0] ? cur_dat[0] : '0;
      rd_a_err   <= !cur_okd[0];
      rd_b_data  <= cur_okd[1] ? cur_dat[1] : '0;
      rd_b_err   <= !cur_okd[1];
      rd_f_flags <= cur_okf ? cur_flg : '0;
      rd_f_err   <= !cur_okf;
    end
  end
endmodule

// File: rtl/ohb_chk.sv
module ohb_chk #(
  parameter int DW = 32,
  parameter int FW = 4,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [DW-1:0] wr_data,
  input logic [IW-1:0] rd_a_idx,
  input logic [DW-1:0] rd_a_data,
  input logic          rd_a_err,
  input logic [DW-1:0] rd_b_data,
  input logic          rd_b_err,
  input logic [FW-1:0] rd_f_flags,
  input logic          rd_f_err,
  input logic          push,
  input logic          pop,
  input logic          ovf,
  input logic          udf
);
  p_newest_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_valid && wr_ready) && rd_a_idx == IW'(1))
      |=> (!rd_a_err && rd_a_data == $past(wr_data, 2)));

  p_zero_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == '0) |=> rd_a_err);

  p_err_zero_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_err |-> (rd_a_data == '0));

  p_err_zero_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_err |-> (rd_b_data == '0));

  p_err_zero_f_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_f_err |-> (rd_f_flags == '0));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push || pop) |-> !wr_ready);

  p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $past(push));

  p_udf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    udf |-> ($past(pop) && !$past(push)));

  p_no_both_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && udf));
endmodule

bind opnd_hist_buf ohb_chk #(.DW(DW), .FW(FW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_data(wr_data), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_a_err(rd_a_err), .rd_b_data(rd_b_data), .rd_b_err(rd_b_err),
  .rd_f_flags(rd_f_flags), .rd_f_err(rd_f_err), .push(push), .pop(pop),
  .ovf(ovf), .udf(udf)
);

// File: tb/opnd_hist_buf_tb.sv
`timescale 1ns/1ps
module opnd_hist_buf_tb;
  localparam int DW = 8, FW = 4, DEPTH = 4, NSAVE = 2;
  localparam int IW = $clog2(DEPTH + 1);
  localparam int NIDX = 1 << IW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, push = 1'b0, pop = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [FW-1:0] wr_flags = '0;
  logic [IW-1:0] rd_a_idx = '0, rd_b_idx = '0, rd_f_idx = '0;
  logic wr_ready, rd_a_err, rd_b_err, rd_f_err, ovf, udf;
  logic [DW-1:0] rd_a_data, rd_b_data;
  logic [FW-1:0] rd_f_flags;

  always #2 clk = ~clk;

  opnd_hist_buf #(.DW(DW), .FW(FW), .DEPTH(DEPTH), .NSAVE(NSAVE)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_flags(wr_flags),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_a_err(rd_a_err),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .rd_b_err(rd_b_err),
    .rd_f_idx(rd_f_idx), .rd_f_flags(rd_f_flags), .rd_f_err(rd_f_err),
    .push(push), .pop(pop), .ovf(ovf), .udf(udf)
  );

  int checks = 0, errors = 0, serial = 0;
  bit finished = 0;
  int mdat [NSAVE+1][DEPTH];
  int mflg [NSAVE+1][DEPTH];
  int mcnt [NSAVE+1];
  int msp = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit hit(input int k);
    return (k >= 1) && (k <= mcnt[msp]);
  endfunction

  // one cycle: inputs applied at a falling edge, results checked at the next
  task automatic step(input string req, input bit v, input bit pu, input bit po,
                      input int ia, input int ib, input int jf);
    int ea, eb, ef, d, f;
    bit oa, ob, of_, eo, eu;
    d = (serial * 29 + 3) & 8'hFF;
    f = (serial * 7 + 1) & 4'hF;
    wr_valid = v; wr_data = DW'(d); wr_flags = FW'(f);
    push = pu; pop = po;
    rd_a_idx = IW'(ia); rd_b_idx = IW'(ib); rd_f_idx = IW'(jf);
    #1;
    chk("R10", "wr_ready", int'(wr_ready), int'(!(pu || po)));
    oa = hit(ia); ob = hit(ib); of_ = hit(jf);
    ea = oa ? mdat[msp][ia-1] : 0;
    eb = ob ? mdat[msp][ib-1] : 0;
    ef = of_ ? mflg[msp][jf-1] : 0;
    eo = pu && (msp == NSAVE);
    eu = !pu && po && (msp == 0);
    @(posedge clk);
    if (v && !pu && !po) begin
      for (int j = DEPTH - 1; j > 0; j--) begin
        mdat[msp][j] = mdat[msp][j-1];
        mflg[msp][j] = mflg[msp][j-1];
      end
      mdat[msp][0] = d; mflg[msp][0] = f;
      if (mcnt[msp] < DEPTH) mcnt[msp]++;
      serial++;
    end
    if (pu) begin
      if (msp < NSAVE) begin msp++; mcnt[msp] = 0; end
    end else if (po && msp > 0) msp--;
    @(negedge clk);
    chk(req, "a_data", int'(rd_a_data), ea);
    chk(req, "a_err", int'(rd_a_err), int'(!oa));
    chk(req, "b_data", int'(rd_b_data), eb);
    chk(req, "b_err", int'(rd_b_err), int'(!ob));
    chk(req, "f_flags", int'(rd_f_flags), ef);
    chk(req, "f_err", int'(rd_f_err), int'(!of_));
    chk("R8", "ovf", int'(ovf), int'(eo));
    chk("R9", "udf", int'(udf), int'(eu));
  endtask

  task automatic sweep(input string req);
    for (int k = 0; k < NIDX; k++) step(req, 0, 0, 0, k, NIDX - 1 - k, k);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int b = 0; b <= NSAVE; b++) mcnt[b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    chk("R11", "a_err", int'(rd_a_err), 0);
    chk("R11", "ovf", int'(ovf), 0);
    chk("R11", "a_data", int'(rd_a_data), 0);
    sweep("R11");
    // R5: writes with reads in the same cycle see pre-write state
    for (int n = 0; n < 6; n++) step("R5", 1, 0, 0, 1, 2, 1);
    // R1, R2, R3, R4: full window, every distance
    sweep("R1/R2/R3/R4");
    // R10: a write offered during push is dropped; R6 new window empty
    step("R10", 1, 1, 0, 1, 1, 1);
    sweep("R6");
    for (int n = 0; n < 3; n++) begin
      step("R6", 1, 0, 0, 1, 2, 3);
      sweep("R6");
    end
    // fill to the top level, then refused push
    step("R6", 0, 1, 0, 0, 0, 0);
    step("R6", 1, 0, 0, 0, 1, 1);
    step("R8", 1, 1, 0, 1, 1, 1);
    sweep("R8");
    // R12: push and pop together at full stack
    step("R12", 1, 1, 1, 1, 2, 1);
    sweep("R12");
    // R7: unwind
    step("R7", 1, 0, 1, 1, 1, 1);
    sweep("R7");
    step("R7", 0, 0, 1, 1, 1, 1);
    sweep("R7");
    // R9: pop on empty stack
    step("R9", 1, 0, 1, 2, 3, 4);
    sweep("R9");
    // R12: push and pop together with room
    step("R12", 0, 1, 1, 1, 1, 1);
    sweep("R12");
    for (int n = 0; n < 5; n++) begin
      step("R3", 1, 0, 0, 4, 1, 4);
      sweep("R3");
    end
    step("R7", 0, 0, 1, 0, 0, 0);
    sweep("R7");
    finish_run();
  end
endmodule